// File: doc/BRIEF.md
# Standby Wake-Up Sequencer

This block decides when a processor leaves a low-power standby state in which its crystal oscillator is stopped. While in standby it watches three kinds of wake source: a bus-request input, a falling-edge non-maskable interrupt, and a set of level-sensitive maskable interrupt inputs. Each source is checked against its own qualifying control bits. On an accepted wake the block turns the oscillator back on and runs a stabilization counter of 2^`STAB_W` clocks. Only then does it re-enable the core clock and the clock output.

When clocking resumes, the block reports one follow-up action. The core clock enable rises in the same cycle as a single-cycle `act_valid` strobe, and a one-hot `act_kind` carries the action. The outcome is a plain strobe with no ready and no back-pressure, because the core must accept it in the cycle it is issued. Bus release works as a small handshake: while the block is running and `busreq` is held, it drops the address and strobe output enables and raises `bus_ack`.

Top module: `standby_wake_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high) leaves the block running with `osc_en`, `core_clk_en` and `clk_out_en` at 1, `standby`, `act_valid` and `bus_ack` at 0, and `addr_oe`/`ctrl_oe` at 1.
- R2: A one-cycle `sleep_req` while running, with `busreq` and `bus_ack` both low, puts the block in standby on the next edge. In standby `osc_en`, `core_clk_en` and `clk_out_en` are 0.
- R3: `busreq` wakes the block only when `busreq_wake_en` is 1. Otherwise the block stays in standby with the oscillator off.
- R4: On an accepted wake, `osc_en` is 1 from the next cycle. `core_clk_en` and `clk_out_en` rise exactly 2^`STAB_W` cycles after that first cycle.
- R5: A falling edge of `nmi_n` seen in standby is latched. The wake completes even if `nmi_n` returns high at once, and the outcome is NMI acknowledge (`act_kind` bit 0).
- R6: A maskable input whose bit in `irq_en` is 0 never wakes the block, whatever the value of `gie`.
- R7: An enabled maskable wake with `gie`=1 gives the interrupt-acknowledge outcome (`act_kind` bit 1), with `act_irq` holding the source index.
- R8: An enabled maskable wake with `gie`=0 gives the continue-after-sleep outcome (`act_kind` bit 2), with no acknowledge.
- R9: A maskable wake is abandoned when no enabled maskable input is active at the end of the window. The block returns to standby with the oscillator off and issues no strobe.
- R10: A wake started by input 0 is abandoned on the edge after input 0 drops during the window, unless an NMI has been latched.
- R11: A bus-request wake gives the bus-release outcome (`act_kind` bit 3). From the next cycle `bus_ack` is 1 and `addr_oe`/`ctrl_oe` are 0. One cycle after `busreq` falls, `bus_ack` is 0 and both enables are 1 again.
- R12: Among sources pending together, NMI wins over maskable inputs, a lower maskable index wins over a higher one, and maskable inputs win over bus request.
- R13: `act_valid` lasts one cycle, and `act_kind` is one-hot when it is 1 and zero otherwise. After any resume or reset, the bus stays released for as long as `busreq` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | One-cycle request to enter standby |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge sensitive |
| irq_req | input | N_IRQ | Maskable interrupt levels, active high |
| busreq | input | 1 | Bus request, active high |
| busreq_wake_en | input | 1 | Allows bus request to wake from standby |
| irq_en | input | N_IRQ | Per-source maskable enables |
| gie | input | 1 | Global interrupt enable flag |
| osc_en | output | 1 | Oscillator run enable |
| core_clk_en | output | 1 | Internal clock enable |
| clk_out_en | output | 1 | System clock output enable |
| standby | output | 1 | Block is in standby |
| addr_oe | output | 1 | Address output enable (0 = tri-state) |
| ctrl_oe | output | 1 | Bus strobe output enable (0 = tri-state) |
| bus_ack | output | 1 | Bus acknowledge |
| act_valid | output | 1 | One-cycle outcome strobe |
| act_kind | output | 4 | One-hot outcome: 0 NMI ack, 1 int ack, 2 continue, 3 bus release |
| act_irq | output | IDW | Maskable source index for the outcome |

## Verification
The hardest situation to reach is a wake that has to be abandoned: a maskable source that goes away partway through the stabilization window. The bench drops input 0 five cycles into the window and expects standby on the very next edge. It drops input 1 at the same point and expects standby only at the window's end. With `STAB_W` reduced to 4, both endings fall on cycles the bench can name exactly. Priority is reached by firing an NMI edge in the same cycle as two maskable inputs and a bus request. The same cycle is then repeated without the NMI edge.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_STBY, ST_WARM} wk_state_e;
  typedef enum logic [1:0] {SRC_NMI, SRC_IRQ, SRC_BUS} wk_src_e;
  localparam int ACT_W      = 4;
  localparam int ACT_NMI    = 0;
  localparam int ACT_INT    = 1;
  localparam int ACT_RESUME = 2;
  localparam int ACT_BUS    = 3;
endpackage

// File: rtl/wk_nmi_latch.sv
module wk_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_n,
  input  logic arm,
  input  logic clear,
  output logic pend
);
  logic prev_q, pend_q, fall;
  assign fall = prev_q & ~nmi_n;
  assign pend = pend_q | (arm & fall);
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_n;
      if (clear)           pend_q <= 1'b0;
      else if (arm & fall) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wk_irq_pick.sv
module wk_irq_pick #(
  parameter int N_IRQ = 3,
  localparam int IDW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             any,
  output logic [IDW-1:0]   id
);
  logic [N_IRQ-1:0] hit;
  assign hit = irq_req & irq_en;
  always_comb begin
    any = 1'b0;
    id  = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any = 1'b1;
        id  = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/wk_stab_counter.sv
module wk_stab_counter #(
  parameter int STAB_W = 17
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic done
);
  logic [STAB_W-1:0] cnt_q;
  assign done = &cnt_q;
  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (en)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wk_bus_release.sv
module wk_bus_release (
  input  logic clk,
  input  logic rst,
  input  logic running,
  input  logic busreq,
  output logic bus_ack,
  output logic addr_oe,
  output logic ctrl_oe
);
  logic rel_q;
  always_ff @(posedge clk) begin
    if (rst) rel_q <= 1'b0;
    else     rel_q <= running & busreq;
  end
  assign bus_ack = rel_q;
  assign addr_oe = ~rel_q;
  assign ctrl_oe = ~rel_q;
endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl
  import wk_pkg::*;
#(
  parameter int STAB_W = 17,
  parameter int N_IRQ  = 3,
  localparam int IDW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic             nmi_n,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic             busreq,
  input  logic             busreq_wake_en,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             gie,
  output logic             osc_en,
  output logic             core_clk_en,
  output logic             clk_out_en,
  output logic             standby,
  output logic             addr_oe,
  output logic             ctrl_oe,
  output logic             bus_ack,
  output logic             act_valid,
  output logic [ACT_W-1:0] act_kind,
  output logic [IDW-1:0]   act_irq
);
  wk_state_e        state_q, state_d;
  wk_src_e          src_q, src_d;
  logic [IDW-1:0]   id_q, id_d;
  logic             nmi_pend, irq_any, stab_done, nmi_clr, cnt_clr;
  logic [IDW-1:0]   irq_id;
  logic             act_v_d;
  logic [ACT_W-1:0] act_k_d;
  logic [IDW-1:0]   act_i_d;
  logic             irq0_lost;

  wk_nmi_latch u_nmi (
    .clk(clk), .rst(rst), .nmi_n(nmi_n),
    .arm(state_q != ST_RUN), .clear(nmi_clr), .pend(nmi_pend)
  );

  wk_irq_pick #(.N_IRQ(N_IRQ)) u_pick (
    .irq_req(irq_req), .irq_en(irq_en), .any(irq_any), .id(irq_id)
  );

  wk_stab_counter #(.STAB_W(STAB_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr),
    .en(state_q == ST_WARM), .done(stab_done)
  );

  wk_bus_release u_bus (
    .clk(clk), .rst(rst), .running(state_q == ST_RUN), .busreq(busreq),
    .bus_ack(bus_ack), .addr_oe(addr_oe), .ctrl_oe(ctrl_oe)
  );

  // wake started by input 0 needs that input for the whole window
  assign irq0_lost = (src_q == SRC_IRQ) && (id_q == '0) && !nmi_pend
                     && !(irq_req[0] & irq_en[0]);

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    id_d    = id_q;
    cnt_clr = 1'b0;
    nmi_clr = 1'b0;
    act_v_d = 1'b0;
    act_k_d = '0;
    act_i_d = '0;
    unique case (state_q)
      ST_RUN: begin
        nmi_clr = 1'b1;
        if (sleep_req && !busreq && !bus_ack) state_d = ST_STBY;
      end
      ST_STBY: begin
        cnt_clr = 1'b1;
        if (nmi_pend) begin
          state_d = ST_WARM;
          src_d   = SRC_NMI;
          id_d    = '0;
        end else if (irq_any) begin
          state_d = ST_WARM;
          src_d   = SRC_IRQ;
          id_d    = irq_id;
        end else if (busreq && busreq_wake_en) begin
          state_d = ST_WARM;
          src_d   = SRC_BUS;
          id_d    = '0;
        end
      end
      ST_WARM: begin
        if (irq0_lost) begin
          state_d = ST_STBY;
        end else if (stab_done) begin
          state_d = ST_RUN;
          act_v_d = 1'b1;
          if (nmi_pend) begin
            act_k_d[ACT_NMI] = 1'b1;
          end else if (src_q == SRC_IRQ) begin
            if (!irq_any) begin
              state_d = ST_STBY;
              act_v_d = 1'b0;
            end else if (gie) begin
              act_k_d[ACT_INT] = 1'b1;
              act_i_d = irq_id;
            end else begin
              act_k_d[ACT_RESUME] = 1'b1;
            end
          end else if (src_q == SRC_BUS) begin
            act_k_d[ACT_BUS] = 1'b1;
          end else begin
            act_k_d[ACT_NMI] = 1'b1;
          end
          if (state_d == ST_RUN) nmi_clr = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      src_q     <= SRC_NMI;
      id_q      <= '0;
      act_valid <= 1'b0;
      act_kind  <= '0;
      act_irq   <= '0;
    end else begin
      state_q   <= state_d;
      src_q     <= src_d;
      id_q      <= id_d;
      act_valid <= act_v_d;
      act_kind  <= act_k_d;
      act_irq   <= act_i_d;
    end
  end

  assign standby     = (state_q == ST_STBY);
  assign osc_en      = (state_q != ST_STBY);
  assign core_clk_en = (state_q == ST_RUN);
  assign clk_out_en  = (state_q == ST_RUN);
endmodule

// File: rtl/standby_wake_ctrl_chk.sv
module standby_wake_ctrl_chk #(
  parameter int N_IRQ = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             nmi_n,
  input logic [N_IRQ-1:0] irq_req,
  input logic [N_IRQ-1:0] irq_en,
  input logic             busreq,
  input logic             busreq_wake_en,
  input logic             standby,
  input logic             osc_en,
  input logic             core_clk_en,
  input logic             bus_ack,
  input logic             act_valid,
  input logic [3:0]       act_kind
);
  a_r4_clock_needs_osc: assert property (@(posedge clk) disable iff (rst)
    core_clk_en |-> osc_en);
  a_r4_strobe_on_resume: assert property (@(posedge clk) disable iff (rst)
    act_valid |-> $rose(core_clk_en));
  a_r13_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
    act_valid |=> !act_valid);
  a_r13_kind_onehot: assert property (@(posedge clk) disable iff (rst)
    act_valid |-> $countones(act_kind) == 1);
  a_r13_kind_idle: assert property (@(posedge clk) disable iff (rst)
    !act_valid |-> act_kind == 4'b0);
  a_r11_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(busreq));
  a_r3_no_spurious_wake: assert property (@(posedge clk) disable iff (rst)
    (standby && nmi_n && $past(nmi_n) && ((irq_req & irq_en) == '0)
     && !(busreq && busreq_wake_en)) |=> standby);
  a_r9_cancel_silent: assert property (@(posedge clk) disable iff (rst)
    $rose(standby) |-> !act_valid);
endmodule

bind standby_wake_ctrl standby_wake_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (.*);

// File: tb/standby_wake_ctrl_test.sv
`timescale 1ns/1ps
module standby_wake_ctrl_test;
  localparam int STAB_W = 4;
  localparam int WIN = 1 << STAB_W;

  logic clk = 1'b0, rst = 1'b1, sleep_req = 1'b0, nmi_n = 1'b1;
  logic [2:0] irq_req = '0, irq_en = '0;
  logic busreq = 1'b0, busreq_wake_en = 1'b0, gie = 1'b0;
  logic osc_en, core_clk_en, clk_out_en, standby, addr_oe, ctrl_oe, bus_ack, act_valid;
  logic [3:0] act_kind;
  logic [1:0] act_irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [5:0] expq[$];

  always #5 clk = ~clk;

  standby_wake_ctrl #(.STAB_W(STAB_W), .N_IRQ(3)) uut (.*);

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_act(logic [3:0] kind, logic [1:0] id);
    expq.push_back({kind, id});
  endtask

  task automatic go_sleep();
    sleep_req = 1'b1;
    cyc(1);
    sleep_req = 1'b0;
    chk(standby && !osc_en, "R2", {standby, osc_en}, 2'b10);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && act_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R13 unexpected outcome", {act_kind, act_irq}, 0);
      end else begin
        logic [5:0] e;
        e = expq.pop_front();
        chk({act_kind, act_irq} == e, "R12 outcome", {act_kind, act_irq}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    cyc(2);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk(!standby && osc_en && core_clk_en && clk_out_en && !act_valid && !bus_ack && addr_oe && ctrl_oe,
        "R1", {standby, osc_en, core_clk_en, bus_ack}, 4'b0110);
    go_sleep();
    chk(!core_clk_en && !clk_out_en, "R2 clocks off", {core_clk_en, clk_out_en}, 0);

    // R6 disabled sources ignored under both gie values
    irq_req = 3'b111; gie = 1'b1;
    cyc(20);
    chk(standby && !osc_en, "R6 gie=1", {standby, osc_en}, 2'b10);
    gie = 1'b0;
    cyc(5);
    chk(standby && !osc_en, "R6 gie=0", {standby, osc_en}, 2'b10);
    irq_req = '0;

    // R3 bus request gated by enable
    busreq = 1'b1;
    cyc(20);
    chk(standby && !osc_en, "R3", {standby, osc_en}, 2'b10);
    busreq = 1'b0;
    cyc(1);

    // R7 / R4 interrupt acknowledge and window length
    irq_en = 3'b111; gie = 1'b1;
    expect_act(4'b0010, 2'd1);
    irq_req = 3'b010;
    cyc(1);
    chk(osc_en && !core_clk_en, "R4 osc on", {osc_en, core_clk_en}, 2'b10);
    cyc(WIN - 1);
    chk(!core_clk_en, "R4 still warming", core_clk_en, 0);
    cyc(1);
    chk(core_clk_en && clk_out_en && act_valid, "R7 resume", {core_clk_en, act_valid}, 2'b11);
    cyc(1);
    chk(!act_valid, "R13 single strobe", act_valid, 0);
    irq_req = '0;
    go_sleep();

    // R8 continue after sleep when global enable is off
    gie = 1'b0;
    expect_act(4'b0100, 2'd0);
    irq_req = 3'b100;
    cyc(WIN + 1);
    chk(core_clk_en, "R8", core_clk_en, 1);
    irq_req = '0;
    cyc(1);
    go_sleep();
    gie = 1'b1;

    // R5 short NMI pulse is latched
    expect_act(4'b0001, 2'd0);
    nmi_n = 1'b0;
    cyc(1);
    nmi_n = 1'b1;
    cyc(WIN);
    chk(core_clk_en, "R5", core_clk_en, 1);
    cyc(1);
    go_sleep();

    // R9 input 1 gone at window end -> back to standby
    irq_req = 3'b010;
    cyc(5);
    irq_req = '0;
    cyc(WIN - 4);
    chk(standby && !osc_en && !core_clk_en, "R9", {standby, osc_en, core_clk_en}, 3'b100);
    cyc(3);

    // R10 input 0 dropped mid-window -> immediate standby
    irq_req = 3'b001;
    cyc(5);
    chk(osc_en && !standby, "R10 warming", {osc_en, standby}, 2'b10);
    irq_req = '0;
    cyc(1);
    chk(standby && !osc_en, "R10", {standby, osc_en}, 2'b10);
    cyc(2);

    // R12 NMI beats maskable and bus request
    busreq_wake_en = 1'b1; busreq = 1'b1; irq_req = 3'b110;
    expect_act(4'b0001, 2'd0);
    nmi_n = 1'b0;
    cyc(1);
    nmi_n = 1'b1;
    cyc(WIN);
    chk(core_clk_en, "R12 nmi first", core_clk_en, 1);
    cyc(1);
    chk(bus_ack && !addr_oe, "R13 bus kept released", {bus_ack, addr_oe}, 2'b10);
    busreq = 1'b0; irq_req = '0;
    cyc(1);
    chk(!bus_ack && addr_oe && ctrl_oe, "R13 bus regained", {bus_ack, addr_oe}, 2'b01);
    go_sleep();

    // R12 lower index beats higher and bus request
    busreq = 1'b1; irq_req = 3'b110;
    expect_act(4'b0010, 2'd1);
    cyc(WIN + 1);
    chk(core_clk_en, "R12 maskable over bus", core_clk_en, 1);
    busreq = 1'b0; irq_req = '0;
    cyc(2);
    go_sleep();

    // R11 bus-request wake and release
    expect_act(4'b1000, 2'd0);
    busreq = 1'b1;
    cyc(WIN + 1);
    chk(core_clk_en && addr_oe, "R11 resume", {core_clk_en, addr_oe}, 2'b11);
    cyc(1);
    chk(bus_ack && !addr_oe && !ctrl_oe, "R11 released", {bus_ack, addr_oe, ctrl_oe}, 3'b100);
    cyc(5);
    chk(bus_ack, "R11 held", bus_ack, 1);
    busreq = 1'b0;
    cyc(1);
    chk(!bus_ack && addr_oe && ctrl_oe && !standby, "R11 regained", {bus_ack, addr_oe, ctrl_oe}, 3'b011);

    // R13 bus stays released after reset while requested
    busreq = 1'b1; rst = 1'b1;
    cyc(1);
    rst = 1'b0;
    cyc(2);
    chk(bus_ack && !addr_oe, "R13 after reset", {bus_ack, addr_oe}, 2'b10);
    busreq = 1'b0;
    cyc(2);

    chk(expq.size() == 0, "R13 all outcomes seen", expq.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule